// File: doc/BRIEF.md
# Data-Phase DMA Port with Command Stop

This block sits between a data-phase byte FIFO and an external device that moves data over a slave-style DMA port. It raises a request when the FIFO can take part in a transfer. The device answers with an acknowledge together with a write strobe or a read strobe, and one byte moves into or out of the FIFO. The other end of the FIFO is served by the bus side through plain push and pop controls. The transfer direction decides which side fills the FIFO and which side drains it.

Two mode inputs can make the running command stop. One makes a data-phase parity error stop it, the other makes detection of ATN stop it. When a stop fires, the block drops its request on its own timing, whatever state the device's handshake is in, and ignores any strobes that follow. It records which event caused the stop and marks the FIFO contents as incomplete. The FIFO must then be cleared before the status-ready output rises again.

Top module: `dphase_dma_port`

## Requirements
- R1: Under reset (synchronous, active low) the FIFO is empty (count 0, empty 1, full 0), port_req is 0, cmd_stopped is 0, stop_cause is 0, fifo_incomplete is 0 and status_ready is 1.
- R2: With xfer_dir = 1 (device writes), port_req is high exactly when run = 1, cmd_stopped = 0 and the FIFO is not full. A cycle with port_req, port_ack and port_wr all high stores port_wdata into the FIFO at that clock edge.
- R3: With xfer_dir = 0 (device reads), port_req is high exactly when run = 1, cmd_stopped = 0 and the FIFO is not empty. port_rdata always shows the oldest byte, and a cycle with port_req, port_ack and port_rd all high removes it.
- R4: port_ack with a strobe in a cycle where port_req is low moves no byte and leaves fifo_count unchanged.
- R5: par_err counts as a stop event only while mode_stop_par = 1, and atn_det only while mode_stop_atn = 1. Either event is ignored while run = 0.
- R6: A stop event sets cmd_stopped at the next clock edge, and port_req is low from that edge on, whether or not the device is acknowledging.
- R7: stop_cause bit 0 means parity and bit 1 means ATN. Both bits are set when both events arrive in the same cycle. The cause is latched when a stop begins, is unchanged while cmd_stopped stays high, and is kept after the stop ends until fifo_clr.
- R8: fifo_incomplete is set together with a stop and stays set until fifo_clr, even after run falls. status_ready is the inverse of fifo_incomplete.
- R9: fifo_clr empties the FIFO and clears fifo_incomplete and stop_cause at the next edge. It overrides a push or pop in the same cycle.
- R10: cmd_stopped returns to 0 at the first edge where run = 0.
- R11: The FIFO delivers bytes first in, first out. fifo_count never exceeds the depth, and fifo_full and fifo_empty follow the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Data phase of a command is active |
| xfer_dir | input | 1 | 1: device writes into FIFO, 0: device reads from FIFO |
| mode_stop_par | input | 1 | Enable stop on parity error |
| mode_stop_atn | input | 1 | Enable stop on ATN detection |
| par_err | input | 1 | Data-phase parity error event |
| atn_det | input | 1 | ATN detected event |
| port_req | output | 1 | DMA request to the device |
| port_ack | input | 1 | DMA acknowledge from the device |
| port_wr | input | 1 | Device write strobe |
| port_rd | input | 1 | Device read strobe |
| port_wdata | input | DATA_W | Byte from the device |
| port_rdata | output | DATA_W | Byte to the device (FIFO head) |
| bus_push | input | 1 | Bus side stores a byte (read direction) |
| bus_wdata | input | DATA_W | Byte from the bus side |
| bus_pop | input | 1 | Bus side takes a byte (write direction) |
| bus_rdata | output | DATA_W | FIFO head for the bus side |
| fifo_clr | input | 1 | Clear FIFO and incomplete flag |
| fifo_count | output | $clog2(DEPTH+1) | Bytes held |
| fifo_full | output | 1 | FIFO full |
| fifo_empty | output | 1 | FIFO empty |
| cmd_stopped | output | 1 | Command stopped by a configured event |
| stop_cause | output | 2 | Bit 0 parity, bit 1 ATN |
| fifo_incomplete | output | 1 | FIFO left incomplete by a stop |
| status_ready | output | 1 | Status phase may proceed |

## Verification
The bench acknowledges right after a stop and checks that the byte count does not move. A design that kept its request up, or that still honoured strobes, would take or give a byte after the stop. It raises a second event while already stopped and both events in one cycle. A design that latched the cause on every event would overwrite the first cause, and one that did not OR the two would lose a bit. It drops run before clearing, to catch an incomplete flag or cause wrongly tied to the stop itself. It also clears while a push is pending, to catch a clear that loses to a push. The bench further fills the FIFO to the full boundary and checks byte order in both directions, so that an off-by-one pointer or a request raised while full shows up as a wrong count or wrong data.

// File: rtl/dphase_pkg.sv
// Shared types for the data-phase DMA port.
// Assumes nothing beyond a 2-bit cause encoding: bit 0 parity, bit 1 ATN.
package dphase_pkg;
    typedef struct packed {
        logic atn;
        logic par;
    } stop_cause_t;
endpackage

// File: rtl/dphase_fifo.sv
// Byte FIFO with head-visible read data and a clear that beats push/pop.
// Assumes DEPTH >= 2; push when full and pop when empty are ignored.
module dphase_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       push,
    input  logic [DATA_W-1:0]          wdata,
    input  logic                       pop,
    output logic [DATA_W-1:0]          rdata,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full,
    output logic                       empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr, rd_ptr;
    logic              do_push, do_pop;

    assign full    = (count == FULL_CNT);
    assign empty   = (count == '0);
    assign do_push = push && !full && !clr;
    assign do_pop  = pop && !empty && !clr;
    assign rdata   = mem[rd_ptr];

    // Storage write on an accepted push.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    // Pointer and occupancy update, with clear taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT); // R11
    AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> empty); // R9
endmodule

// File: rtl/dphase_stop_ctl.sv
// Command-stop controller: qualifies parity/ATN events with mode bits,
// holds the stopped state for the rest of the data phase, latches the
// cause and the FIFO-incomplete flag until software clears the FIFO.
// Assumes events are single-cycle-or-longer levels sampled on clk.
module dphase_stop_ctl
    import dphase_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        run,
    input  logic        mode_par,
    input  logic        mode_atn,
    input  logic        par_err,
    input  logic        atn_det,
    input  logic        clr,
    output logic        stopped,
    output stop_cause_t cause,
    output logic        incomplete
);
    logic        hit_par, hit_atn, new_stop;

    assign hit_par  = run && mode_par && par_err;
    assign hit_atn  = run && mode_atn && atn_det;
    assign new_stop = (hit_par || hit_atn) && !stopped;

    // Stopped state lives for the remainder of the data phase.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) stopped <= 1'b0;
        else if (new_stop)  stopped <= 1'b1;
    end

    // Cause and incomplete flag: a fresh stop wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause      <= '0;
            incomplete <= 1'b0;
        end else if (new_stop) begin
            cause      <= '{atn: hit_atn, par: hit_par};
            incomplete <= 1'b1;
        end else if (clr) begin
            cause      <= '0;
            incomplete <= 1'b0;
        end
    end

    AST_CAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        stopped && !clr |=> $stable(cause)); // R7
    AST_INC_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stopped) |-> incomplete); // R8
endmodule

// File: rtl/dphase_port_hs.sv
// Port-side handshake: forms the request from FIFO state and the stop
// state, and qualifies acknowledge plus strobe into a one-byte transfer.
// Assumes the device samples port_req and answers in the same cycle.
module dphase_port_hs (
    input  logic run,
    input  logic stopped,
    input  logic dir_wr,
    input  logic fifo_full,
    input  logic fifo_empty,
    input  logic ack,
    input  logic wr,
    input  logic rd,
    output logic req,
    output logic xfer
);
    logic room;

    // Room for a transfer in the selected direction.
    always_comb room = dir_wr ? !fifo_full : !fifo_empty;

    // Request and qualified transfer; strobes without request are dropped.
    always_comb begin
        req  = run && !stopped && room;
        xfer = req && ack && (dir_wr ? wr : rd);
    end
endmodule

// File: rtl/dphase_dma_port.sv
// Top: data-phase DMA port with command stop on parity error or ATN.
// Device side fills the FIFO when xfer_dir=1 and drains it when 0; the
// bus side takes the opposite end. Assumes synchronous active-low reset.
module dphase_dma_port
    import dphase_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       run,
    input  logic                       xfer_dir,
    input  logic                       mode_stop_par,
    input  logic                       mode_stop_atn,
    input  logic                       par_err,
    input  logic                       atn_det,
    output logic                       port_req,
    input  logic                       port_ack,
    input  logic                       port_wr,
    input  logic                       port_rd,
    input  logic [DATA_W-1:0]          port_wdata,
    output logic [DATA_W-1:0]          port_rdata,
    input  logic                       bus_push,
    input  logic [DATA_W-1:0]          bus_wdata,
    input  logic                       bus_pop,
    output logic [DATA_W-1:0]          bus_rdata,
    input  logic                       fifo_clr,
    output logic [$clog2(DEPTH+1)-1:0] fifo_count,
    output logic                       fifo_full,
    output logic                       fifo_empty,
    output logic                       cmd_stopped,
    output logic [1:0]                 stop_cause,
    output logic                       fifo_incomplete,
    output logic                       status_ready
);
    logic              xfer, f_push, f_pop;
    logic [DATA_W-1:0] f_wdata, f_rdata;
    stop_cause_t       cause;

    dphase_stop_ctl u_stop (
        .clk(clk), .rst_n(rst_n), .run(run),
        .mode_par(mode_stop_par), .mode_atn(mode_stop_atn),
        .par_err(par_err), .atn_det(atn_det), .clr(fifo_clr),
        .stopped(cmd_stopped), .cause(cause), .incomplete(fifo_incomplete)
    );

    dphase_port_hs u_hs (
        .run(run), .stopped(cmd_stopped), .dir_wr(xfer_dir),
        .fifo_full(fifo_full), .fifo_empty(fifo_empty),
        .ack(port_ack), .wr(port_wr), .rd(port_rd),
        .req(port_req), .xfer(xfer)
    );

    // Steer FIFO ends by direction.
    always_comb begin
        f_push  = xfer_dir ? xfer       : bus_push;
        f_wdata = xfer_dir ? port_wdata : bus_wdata;
        f_pop   = xfer_dir ? bus_pop    : xfer;
    end

    dphase_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .clr(fifo_clr),
        .push(f_push), .wdata(f_wdata), .pop(f_pop),
        .rdata(f_rdata), .count(fifo_count),
        .full(fifo_full), .empty(fifo_empty)
    );

    assign port_rdata   = f_rdata;
    assign bus_rdata    = f_rdata;
    assign stop_cause   = cause;
    assign status_ready = !fifo_incomplete;

    AST_STOP_DROPS_WR: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stopped && xfer_dir && !bus_pop && !fifo_clr
        |=> fifo_count == $past(fifo_count)); // R6
    AST_STOP_DROPS_RD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stopped && !xfer_dir && !bus_push && !fifo_clr
        |=> fifo_count == $past(fifo_count)); // R4
endmodule

// File: tb/sim_dphase_dma_port.sv
`timescale 1ns/1ps
module sim_dphase_dma_port;
    localparam int DW = 8;
    localparam int DP = 4;
    localparam int NV = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run = 0, xfer_dir = 0, mode_stop_par = 0, mode_stop_atn = 0;
    logic par_err = 0, atn_det = 0, port_ack = 0, port_wr = 0, port_rd = 0;
    logic bus_push = 0, bus_pop = 0, fifo_clr = 0;
    logic [DW-1:0] port_wdata = '0, bus_wdata = '0;
    logic port_req, fifo_full, fifo_empty, cmd_stopped, fifo_incomplete, status_ready;
    logic [DW-1:0] port_rdata, bus_rdata;
    logic [2:0] fifo_count;
    logic [1:0] stop_cause;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    dphase_dma_port #(.DATA_W(DW), .DEPTH(DP)) u0 (
        .clk(clk), .rst_n(rst_n), .run(run), .xfer_dir(xfer_dir),
        .mode_stop_par(mode_stop_par), .mode_stop_atn(mode_stop_atn),
        .par_err(par_err), .atn_det(atn_det), .port_req(port_req),
        .port_ack(port_ack), .port_wr(port_wr), .port_rd(port_rd),
        .port_wdata(port_wdata), .port_rdata(port_rdata),
        .bus_push(bus_push), .bus_wdata(bus_wdata), .bus_pop(bus_pop),
        .bus_rdata(bus_rdata), .fifo_clr(fifo_clr), .fifo_count(fifo_count),
        .fifo_full(fifo_full), .fifo_empty(fifo_empty),
        .cmd_stopped(cmd_stopped), .stop_cause(stop_cause),
        .fifo_incomplete(fifo_incomplete), .status_ready(status_ready)
    );

    // Stimulus {dir run mpar matn perr atn ack wr rd push pop clr}
    // Expected after the edge {req stopped incomplete cause[1:0] count[2:0]}
    localparam logic [19:0] VEC [NV] = '{
        20'b1100_0000_0000_1000_0000, // R2 enter write direction
        20'b1100_0011_0000_1000_0001, // R2 device write
        20'b1100_0011_0000_1000_0010,
        20'b1100_0011_0000_1000_0011,
        20'b1100_0011_0000_0000_0100, // R11 full, request drops
        20'b1100_0011_0000_0000_0100, // R4 strobe without request
        20'b1100_0000_0010_1000_0011, // R11 bus pop
        20'b1100_1000_0000_1000_0011, // R5 parity with mode off
        20'b1110_1000_0000_0110_1011, // R6 parity stop
        20'b1110_0011_0000_0110_1011, // R6 ack after stop dropped
        20'b1101_0100_0000_0110_1011, // R7 second event keeps cause
        20'b1000_0000_0000_0010_1011, // R10 run low, R8 flag held
        20'b1000_0000_0001_0000_0000, // R9 clear
        20'b0100_0000_0100_1000_0001, // R3 bus push, read direction
        20'b0100_0010_1000_0000_0000, // R3 device read
        20'b0100_0000_0100_1000_0001,
        20'b0101_0100_0000_0111_0001, // R6 ATN stop
        20'b0101_0010_1000_0111_0001, // R4 read after stop dropped
        20'b0000_0000_0001_0000_0000, // R9 clear
        20'b0011_1100_0000_0000_0000  // R5 events while run low
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [11:0] s);
        {xfer_dir, run, mode_stop_par, mode_stop_atn, par_err, atn_det,
         port_ack, port_wr, port_rd, bus_push, bus_pop, fifo_clr} = s;
    endtask

    task automatic tick;
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        tick; tick;
        chk("R1 count", 32'(fifo_count), 0);
        chk("R1 req", 32'(port_req), 0);
        chk("R1 stopped", 32'(cmd_stopped), 0);
        chk("R1 cause", 32'(stop_cause), 0);
        chk("R1 ready", 32'(status_ready), 1);
        chk("R1 empty", 32'(fifo_empty), 1);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][19:8]);
            port_wdata = DW'(i + 16);
            bus_wdata  = DW'(i + 64);
            tick;
            chk($sformatf("R2/R3 vec%0d req", i), 32'(port_req), 32'(VEC[i][7]));
            chk($sformatf("R6/R10 vec%0d stopped", i), 32'(cmd_stopped), 32'(VEC[i][6]));
            chk($sformatf("R8 vec%0d incomplete", i), 32'(fifo_incomplete), 32'(VEC[i][5]));
            chk($sformatf("R8 vec%0d ready", i), 32'(status_ready), 32'(!VEC[i][5]));
            chk($sformatf("R7 vec%0d cause", i), 32'(stop_cause), 32'(VEC[i][4:3]));
            chk($sformatf("R11 vec%0d count", i), 32'(fifo_count), 32'(VEC[i][2:0]));
        end
        drive('0);

        // R7: both events in one cycle set both cause bits.
        run = 1; xfer_dir = 1; mode_stop_par = 1; mode_stop_atn = 1;
        par_err = 1; atn_det = 1;
        tick;
        chk("R7 both causes", 32'(stop_cause), 32'h3);
        drive('0); fifo_clr = 1; tick; fifo_clr = 0;

        // R11 and R2: order of bytes written by the device.
        run = 1; xfer_dir = 1; port_ack = 1; port_wr = 1;
        port_wdata = 8'hA5; tick;
        port_wdata = 8'h3C; tick;
        port_ack = 0; port_wr = 0;
        chk("R11 head first", 32'(bus_rdata), 32'hA5);
        chk("R11 full flag", 32'(fifo_full), 0);
        bus_pop = 1; tick; bus_pop = 0;
        chk("R11 head second", 32'(bus_rdata), 32'h3C);

        // R9: clear beats a simultaneous push.
        xfer_dir = 0; bus_push = 1; bus_wdata = 8'h77; fifo_clr = 1; tick;
        bus_push = 0; fifo_clr = 0;
        chk("R9 clear over push", 32'(fifo_count), 0);

        // R3: device sees the pushed byte.
        bus_push = 1; bus_wdata = 8'h77; tick; bus_push = 0;
        chk("R3 rdata", 32'(port_rdata), 32'h77);
        chk("R3 req", 32'(port_req), 1);

        // R1: reset mid-operation after a stop.
        mode_stop_atn = 1; atn_det = 1; tick; atn_det = 0;
        chk("R6 stopped before reset", 32'(cmd_stopped), 1);
        rst_n = 0; tick; rst_n = 1;
        chk("R1 reset clears stop", 32'(cmd_stopped), 0);
        chk("R1 reset clears flag", 32'(fifo_incomplete), 0);
        chk("R1 reset empties", 32'(fifo_count), 0);
        drive('0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule